// File: doc/BRIEF.md
# Two-Digit Even Decimal Counter

This block counts the even numbers from 00 to 98 in decimal and then starts again at 00. The count is held as two 4-bit BCD digits. The ones digit moves in steps of two and never sets its lowest bit. The tens digit moves by one each time the ones digit rolls over. Both digits are also decoded into active-high seven-segment patterns, so they can drive two displays directly.

All state changes on the rising clock edge. The tens digit is advanced by a synchronous carry term and is never clocked by a derived edge. A synchronous reset clears the count, and a count enable lets the count hold between steps. A one-cycle wrap flag marks the step that returns the count from 98 to 00, which lets a following stage count whole cycles of 50 steps.

Top module: `even_bcd_counter`

## Requirements
- R1: When `rst` is high at a rising edge, both digits are 0 and `wrap` is 0 after that edge, whatever the value of `en`.
- R2: On each rising edge with `en` high and `rst` low, the ones digit moves through 0, 2, 4, 6 and 8 in that order, and from 8 it returns to 0.
- R3: Bit 0 of `ones_bcd` is 0 in every cycle after reset, and the ones digit never goes above 8.
- R4: The tens digit goes up by one only on an enabled edge where the ones digit goes from 8 to 0. On every other edge it keeps its value.
- R5: The tens digit stays within 0 to 9. An enabled edge taken at count 98 sets the count to 00, so one full cycle has 50 distinct states.
- R6: On an edge with `en` low and `rst` low, both digits keep their values.
- R7: `wrap` is high for exactly the one cycle that follows an enabled edge taking the count from 98 to 00. In every other cycle it is low, so it pulses once per 50 enabled steps.
- R8: `ones_seg` and `tens_seg` show the current digit combinationally. Bit order is {g,f,e,d,c,b,a} and a 1 turns a segment on. Segment a lights for 0,2,3,5,6,7,8,9; b for 0,1,2,3,4,7,8,9; c for all digits except 2; d for 0,2,3,5,6,8,9; e for 0,2,6,8; f for 0,4,5,6,8,9; g for 2,3,4,5,6,8,9. Any non-BCD value turns every segment off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, takes priority over `en` |
| en | input | 1 | Count enable, active high |
| ones_bcd | output | 4 | Ones digit in BCD (even values only) |
| tens_bcd | output | 4 | Tens digit in BCD |
| ones_seg | output | 7 | Segment pattern of the ones digit, {g,f,e,d,c,b,a} |
| tens_seg | output | 7 | Segment pattern of the tens digit, {g,f,e,d,c,b,a} |
| wrap | output | 1 | One-cycle flag after the 98-to-00 step |

## Verification
The assertions assume that `rst` is held high from time zero through at least one rising edge, and that `en` and `rst` have known values at every edge, because the step and hold properties compare each state with the state one edge earlier. The stimulus meets both conditions. It drives every input only on falling edges, starts with reset high and enable low, and then keeps both inputs at defined levels through long enabled runs, irregular enable patterns, a hold exactly at count 98, and a reset asserted while counting is enabled.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;

  typedef logic [DIGIT_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0]   seg_t;

  // Modular step of one digit: wraps to zero once it has reached the last value.
  function automatic bcd_t digit_step(bcd_t cur, bcd_t inc, bcd_t last);
    return (cur >= last) ? '0 : bcd_t'(cur + inc);
  endfunction

  // BCD to segment pattern, active high, bit order {g,f,e,d,c,b,a}.
  function automatic seg_t bcd_to_seg(bcd_t d);
    seg_t s;
    case (d)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/ebc_ones_digit.sv
module ebc_ones_digit
  import ebc_pkg::*;
#(
  parameter int STEP = 2,
  parameter int LAST = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output bcd_t digit,
  output logic at_last
);
  localparam bcd_t STEP_B = bcd_t'(STEP);
  localparam bcd_t LAST_B = bcd_t'(LAST);

  bcd_t digit_q;

  always_ff @(posedge clk) begin
    if (rst)     digit_q <= '0;
    else if (en) digit_q <= digit_step(digit_q, STEP_B, LAST_B);
  end

  assign digit   = digit_q;
  assign at_last = (digit_q == LAST_B);
endmodule

// File: rtl/ebc_tens_digit.sv
module ebc_tens_digit
  import ebc_pkg::*;
#(
  parameter int LAST = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  output bcd_t digit,
  output logic at_last
);
  localparam bcd_t LAST_B = bcd_t'(LAST);
  localparam bcd_t ONE_B  = bcd_t'(1);

  bcd_t digit_q;

  always_ff @(posedge clk) begin
    if (rst)          digit_q <= '0;
    else if (advance) digit_q <= digit_step(digit_q, ONE_B, LAST_B);
  end

  assign digit   = digit_q;
  assign at_last = (digit_q == LAST_B);
endmodule

// File: rtl/ebc_seg_decode.sv
module ebc_seg_decode
  import ebc_pkg::*;
(
  input  bcd_t digit,
  output seg_t seg
);
  assign seg = bcd_to_seg(digit);
endmodule

// File: rtl/even_bcd_counter.sv
module even_bcd_counter
  import ebc_pkg::*;
#(
  parameter int ONES_STEP = 2,
  parameter int ONES_LAST = 8,
  parameter int TENS_LAST = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic [3:0] ones_bcd,
  output logic [3:0] tens_bcd,
  output logic [6:0] ones_seg,
  output logic [6:0] tens_seg,
  output logic       wrap
);
  localparam int NUM_DIGITS = 2;

  // Named internal events, visible to the bound checker.
  logic ones_carry;   // ones digit sits at its last value
  logic tens_last;    // tens digit sits at its last value
  logic tens_adv;     // synchronous carry into the tens digit
  logic wrap_now;     // this edge takes the count back to zero
  logic wrap_q;

  bcd_t ones_d, tens_d;
  bcd_t digits [NUM_DIGITS];
  seg_t segs   [NUM_DIGITS];

  ebc_ones_digit #(.STEP(ONES_STEP), .LAST(ONES_LAST)) u_ones (
    .clk(clk), .rst(rst), .en(en), .digit(ones_d), .at_last(ones_carry)
  );

  assign tens_adv = en & ones_carry;

  ebc_tens_digit #(.LAST(TENS_LAST)) u_tens (
    .clk(clk), .rst(rst), .advance(tens_adv), .digit(tens_d), .at_last(tens_last)
  );

  assign wrap_now = tens_adv & tens_last;

  always_ff @(posedge clk) begin
    if (rst) wrap_q <= 1'b0;
    else     wrap_q <= wrap_now;
  end

  assign digits[0] = ones_d;
  assign digits[1] = tens_d;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dec
    ebc_seg_decode u_dec (.digit(digits[i]), .seg(segs[i]));
  end

  assign ones_bcd = ones_d;
  assign tens_bcd = tens_d;
  assign ones_seg = segs[0];
  assign tens_seg = segs[1];
  assign wrap     = wrap_q;
endmodule

// File: rtl/ebc_checker.sv
module ebc_checker (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [3:0] ones_bcd,
  input logic [3:0] tens_bcd,
  input logic       wrap,
  input logic       ones_carry
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (ones_bcd == 4'd0 && tens_bcd == 4'd0 && !wrap));

  // R2
  a_r2_ones_step: assert property (@(posedge clk) disable iff (rst)
    en |=> ones_bcd == (($past(ones_bcd) == 4'd8) ? 4'd0 : $past(ones_bcd) + 4'd2));

  // R3
  a_r3_ones_even: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (ones_bcd[0] == 1'b0 && ones_bcd <= 4'd8));

  // R4
  a_r4_tens_carry: assert property (@(posedge clk) disable iff (rst)
    (en && ones_carry) |=> tens_bcd == (($past(tens_bcd) == 4'd9) ? 4'd0 : $past(tens_bcd) + 4'd1));

  a_r4_tens_hold: assert property (@(posedge clk) disable iff (rst)
    !(en && ones_carry) |=> $stable(tens_bcd));

  // R5
  a_r5_tens_range: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> tens_bcd <= 4'd9);

  // R6
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(ones_bcd) && $stable(tens_bcd)));

  // R7
  a_r7_wrap_set: assert property (@(posedge clk) disable iff (rst)
    (en && ones_bcd == 4'd8 && tens_bcd == 4'd9) |=> wrap);

  a_r7_wrap_at_zero: assert property (@(posedge clk) disable iff (rst)
    wrap |-> (ones_bcd == 4'd0 && tens_bcd == 4'd0));

  a_r7_wrap_single: assert property (@(posedge clk) disable iff (rst)
    wrap |=> !wrap);
endmodule

bind even_bcd_counter ebc_checker u_chk (
  .clk(clk), .rst(rst), .en(en),
  .ones_bcd(ones_bcd), .tens_bcd(tens_bcd),
  .wrap(wrap), .ones_carry(ones_carry)
);

// File: tb/tb_even_bcd_counter.sv
module tb_even_bcd_counter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [3:0] ones_bcd, tens_bcd;
  logic [6:0] ones_seg, tens_seg;
  logic       wrap;

  int checks = 0;
  int failures = 0;
  int exp_wraps = 0;
  int act_wraps = 0;
  int model_n = 0;     // model value 0..98
  bit done = 1'b0;

  typedef struct {
    int    n;
    bit    wrap;
    string tag_ones;
    string tag_tens;
  } exp_t;

  exp_t sb[$];

  even_bcd_counter dut (
    .clk(clk), .rst(rst), .en(en),
    .ones_bcd(ones_bcd), .tens_bcd(tens_bcd),
    .ones_seg(ones_seg), .tens_seg(tens_seg),
    .wrap(wrap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Segment pattern rebuilt from per-segment digit sets (bit i = digit i lit).
  function automatic logic [6:0] ref_seg(int d);
    logic [9:0] lit [7];
    logic [6:0] s;
    lit[0] = 10'b1111101101; // a
    lit[1] = 10'b1110011111; // b
    lit[2] = 10'b1111111011; // c
    lit[3] = 10'b1101101101; // d
    lit[4] = 10'b0101000101; // e
    lit[5] = 10'b1101110001; // f
    lit[6] = 10'b1101111100; // g
    for (int k = 0; k < 7; k++) s[k] = lit[k][d];
    return s;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: set inputs for the next edge and push the expected result.
  task automatic step(bit r, bit e);
    exp_t x;
    int prev;
    @(negedge clk);
    rst = r;
    en  = e;
    prev = model_n;
    x.wrap = 1'b0;
    if (r) begin
      model_n = 0;
      x.tag_ones = "R1";
      x.tag_tens = "R1";
    end else if (!e) begin
      x.tag_ones = "R6";
      x.tag_tens = "R6";
    end else begin
      model_n = (model_n + 2) % 100;
      x.tag_ones = "R2";
      x.tag_tens = (prev == 98) ? "R5" : "R4";
      if (prev == 98) begin
        x.wrap = 1'b1;
        exp_wraps++;
      end
    end
    x.n = model_n;
    sb.push_back(x);
  endtask

  // Monitor: after each edge, compare against the oldest expected item.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        check(ones_bcd == 4'(x.n % 10), x.tag_ones, "ones_bcd", int'(ones_bcd), x.n % 10);
        check(tens_bcd == 4'(x.n / 10), x.tag_tens, "tens_bcd", int'(tens_bcd), x.n / 10);
        check(ones_bcd[0] == 1'b0, "R3", "ones_bcd lsb", int'(ones_bcd[0]), 0);
        check(wrap == x.wrap, (x.tag_ones == "R1") ? "R1" : "R7", "wrap", int'(wrap), int'(x.wrap));
        check(ones_seg == ref_seg(x.n % 10), "R8", "ones_seg", int'(ones_seg), int'(ref_seg(x.n % 10)));
        check(tens_seg == ref_seg(x.n / 10), "R8", "tens_seg", int'(tens_seg), int'(ref_seg(x.n / 10)));
        if (wrap) act_wraps++;
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset with enable low, then with enable high (priority).
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    // R2, R4, R5, R7: two full cycles plus a bit.
    for (int i = 0; i < 110; i++) step(1'b0, 1'b1);
    // R6: irregular enable pattern.
    for (int i = 0; i < 120; i++) step(1'b0, 1'(($urandom() % 3) != 0));
    // Park at 98, hold there, then wrap.
    step(1'b1, 1'b0);
    for (int i = 0; i < 49; i++) step(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);   // R6 hold at 98, no R7 wrap
    step(1'b0, 1'b1);                               // R5/R7 98 -> 00
    step(1'b0, 1'b1);
    // R1: reset in the middle of an enabled run.
    for (int i = 0; i < 7; i++) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    repeat (3) @(posedge clk);
    // R7: one wrap pulse per full cycle, counted over the whole run.
    check(act_wraps == exp_wraps, "R7", "wrap pulse count", act_wraps, exp_wraps);
    check(sb.size() == 0, "R2", "scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule